// File: doc/BRIEF.md
# Pattern-Driven Memory Access Sequencer

This block sequences one memory access by stepping through a small table of pattern words. A requester loads a start index. From the next cycle on, the sequencer shows one pattern word per clock on a set of strobe outputs and a data-latch enable, and it moves to the following entry on each clock. A word whose last bit is set ends the access, and a single-cycle done pulse follows it. Software-side logic fills the table through a write port. That port accepts writes only while the sequencer is idle.

Slow slaves, or slaves with an unpredictable response time, can hold an asynchronous wait line. A two-flop synchronizer brings this line into the clock domain. When the wait function is enabled and the synchronized wait is high, the sequencer stops on any word that has its wait-enable bit set. It keeps that word's strobes on the outputs and gives no data-latch enable until the wait drops. It then carries on with the next entry.

The state machine has three states. IDLE waits for a request. RUN executes one word per cycle. FREEZE holds a word that is waiting. Five transitions connect them:
- START goes from IDLE to RUN on a request.
- STEP goes from RUN to RUN on a plain word.
- HALT goes from RUN to FREEZE on a wait-enabled word while the synchronized wait is high.
- RESUME goes from FREEZE to RUN on release, when the held word is not last.
- FINISH goes from RUN or FREEZE to IDLE when a last word completes.

Top module: `mem_seq_top`

## Requirements
- R1: After reset the strobes, the latch enable and done are all low and the sequencer is idle. While idle, the strobes and the latch enable stay low.
- R2: A request sampled at a clock edge while idle loads the pointer with `req_idx`. The word at that index drives `strb_o` (word bits 3:0) in the cycle after the request edge, and each later cycle shows the next entry.
- R3: Word bit 4 drives `latch_o` high during the cycle that word is executed, unless R9 applies.
- R4: A word with bit 6 set is the final one. In the cycle after it, `req_done` is high for exactly one cycle, the strobes are low, and the sequencer is idle.
- R5: With `cfg_wait_en` low, `ext_wait` has no effect on the output sequence.
- R6: `ext_wait` passes through two flip-flops. A rise that is driven before the request edge freezes on a wait-enabled word reached two edges later. A rise one cycle later does not.
- R7: When a word with bit 5 set executes while the wait function is enabled and the synchronized wait is high, the pointer and the strobes stay on that word for as long as the synchronized wait stays high.
- R8: The clock edge after the synchronized wait falls moves to the next entry. Counted from the cycle in which `ext_wait` is first driven low, the frozen word is shown for three cycles, and the next entry appears in the fourth.
- R9: `latch_o` stays low while frozen. This includes the first cycle of a wait-enabled word that freezes.
- R10: Pattern writes (`pat_we`) are ignored while an access is in progress and take effect while idle.
- R11: A request that arrives while an access is in progress is ignored, and the current sequence goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wait_en | input | 1 | Enables the wait-freeze function |
| req_start | input | 1 | Access request |
| req_idx | input | 4 | First pattern entry of the access |
| req_done | output | 1 | One-cycle pulse after the final word |
| pat_we | input | 1 | Pattern table write strobe |
| pat_addr | input | 4 | Pattern table write index |
| pat_wdata | input | 7 | Pattern word: strobes 3:0, latch 4, wait-enable 5, last 6 |
| ext_wait | input | 1 | Asynchronous wait from the slave |
| strb_o | output | 4 | Strobe outputs of the current word |
| latch_o | output | 1 | Data-latch enable |

## Verification
Two events can fall in the same cycle: the synchronized wait rises at the same edge on which the wait-enabled word becomes current. The bench provokes this by raising `ext_wait` together with the request, so that the second synchronizer flop changes just as the pointer reaches the wait-enabled entry. It expects a freeze with no skipped cycle. A second run raises the wait one cycle later and expects the word to pass straight through. The other overlap is a wait-enabled word that also carries the latch bit. In that case the bench checks that the latch enable stays low in the first cycle of the word and in every frozen cycle.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FREEZE = 2'd2
    } seq_state_t;

    localparam int STRB_BITS = 4;
    localparam int LATCH_POS = STRB_BITS;
    localparam int WAIT_POS  = STRB_BITS + 1;
    localparam int LAST_POS  = STRB_BITS + 2;
    localparam int PWORD_W   = STRB_BITS + 3;

endpackage

// File: rtl/mseq_sync.sv
module mseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        genvar g;
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mseq_pattern_ram.sv
module mseq_pattern_ram #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 7,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    generate
        genvar e;
        for (e = 0; e < DEPTH; e++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[e] <= '0;
                else if (wr_en && (wr_addr == AW'(e)))
                    mem[e] <= wr_data;
            end
        end
    endgenerate

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mseq_fsm.sv
module mseq_fsm
    import mseq_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int STRB_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic              cfg_wait_en,
    input  logic              wait_s,
    input  logic [STRB_W-1:0] word_strb,
    input  logic              word_latch,
    input  logic              word_wait,
    input  logic              word_last,
    output logic [IDX_W-1:0]  ptr_o,
    output logic              idle_o,
    output logic              frozen_o,
    output logic              done_o,
    output logic [STRB_W-1:0] strb_o,
    output logic              latch_o
);
    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic             done_q;
    logic             hold;
    logic             halt;

    assign hold = cfg_wait_en && wait_s;
    assign halt = word_wait && hold;

    // next-state and pointer
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin                 // START
                    state_d = ST_RUN;
                    ptr_d   = start_idx;
                end
            end
            ST_RUN: begin
                if (halt) begin                  // HALT
                    state_d = ST_FREEZE;
                end else if (word_last) begin    // FINISH
                    state_d = ST_IDLE;
                end else begin                   // STEP
                    ptr_d = ptr_q + 1'b1;
                end
            end
            ST_FREEZE: begin
                if (!hold) begin
                    if (word_last) begin         // FINISH
                        state_d = ST_IDLE;
                    end else begin               // RESUME
                        state_d = ST_RUN;
                        ptr_d   = ptr_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            done_q  <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
        end
    end

    // outputs
    always_comb begin
        strb_o  = '0;
        latch_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                strb_o  = '0;
                latch_o = 1'b0;
            end
            ST_RUN: begin
                strb_o  = word_strb;
                latch_o = word_latch && !halt;
            end
            ST_FREEZE: begin
                strb_o  = word_strb;
                latch_o = 1'b0;
            end
            default: begin
                strb_o  = '0;
                latch_o = 1'b0;
            end
        endcase
    end

    assign ptr_o    = ptr_q;
    assign idle_o   = (state_q == ST_IDLE);
    assign frozen_o = (state_q == ST_FREEZE);
    assign done_o   = done_q;
endmodule

// File: rtl/mem_seq_top.sv
module mem_seq_top
    import mseq_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wait_en,
    input  logic                 req_start,
    input  logic [IDX_W-1:0]     req_idx,
    output logic                 req_done,
    input  logic                 pat_we,
    input  logic [IDX_W-1:0]     pat_addr,
    input  logic [PWORD_W-1:0]   pat_wdata,
    input  logic                 ext_wait,
    output logic [STRB_BITS-1:0] strb_o,
    output logic                 latch_o
);
    logic               wait_s;
    logic               idle;
    logic               frozen;
    logic [IDX_W-1:0]   ptr;
    logic [PWORD_W-1:0] cur_word;

    mseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_wait),
        .sync_out (wait_s)
    );

    mseq_pattern_ram #(.DEPTH(DEPTH), .WORD_W(PWORD_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pat_we && idle),
        .wr_addr (pat_addr),
        .wr_data (pat_wdata),
        .rd_addr (ptr),
        .rd_data (cur_word)
    );

    mseq_fsm #(.IDX_W(IDX_W), .STRB_W(STRB_BITS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (req_start),
        .start_idx   (req_idx),
        .cfg_wait_en (cfg_wait_en),
        .wait_s      (wait_s),
        .word_strb   (cur_word[STRB_BITS-1:0]),
        .word_latch  (cur_word[LATCH_POS]),
        .word_wait   (cur_word[WAIT_POS]),
        .word_last   (cur_word[LAST_POS]),
        .ptr_o       (ptr),
        .idle_o      (idle),
        .frozen_o    (frozen),
        .done_o      (req_done),
        .strb_o      (strb_o),
        .latch_o     (latch_o)
    );
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
    parameter int STRB_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wait_en,
    input logic              wait_s,
    input logic              idle,
    input logic              frozen,
    input logic              req_done,
    input logic [STRB_W-1:0] strb_o,
    input logic              latch_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (strb_o == '0 && !latch_o)); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done); // R4

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> (idle && strb_o == '0)); // R4

    AST_FREEZE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frozen) |-> $past(cfg_wait_en && wait_s)); // R5

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && $past(frozen)) |-> $stable(strb_o)); // R7

    AST_NO_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> !latch_o); // R9
endmodule

bind mem_seq_top mseq_chk #(.STRB_W(mseq_pkg::STRB_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wait_en (cfg_wait_en),
    .wait_s      (wait_s),
    .idle        (idle),
    .frozen      (frozen),
    .req_done    (req_done),
    .strb_o      (strb_o),
    .latch_o     (latch_o)
);

// File: tb/mem_seq_top_test.sv
`timescale 1ns/1ps
module mem_seq_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wait_en = 1'b0;
    logic       req_start = 1'b0;
    logic [3:0] req_idx = '0;
    logic       req_done;
    logic       pat_we = 1'b0;
    logic [3:0] pat_addr = '0;
    logic [6:0] pat_wdata = '0;
    logic       ext_wait = 1'b0;
    logic [3:0] strb_o;
    logic       latch_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    mem_seq_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_wait_en(cfg_wait_en),
        .req_start(req_start), .req_idx(req_idx), .req_done(req_done),
        .pat_we(pat_we), .pat_addr(pat_addr), .pat_wdata(pat_wdata),
        .ext_wait(ext_wait), .strb_o(strb_o), .latch_o(latch_o)
    );

    // compare at the current negedge, then advance one cycle
    task automatic chk(input logic [3:0] es, input logic el, input logic ed, input string req);
        checks++;
        if (strb_o !== es || latch_o !== el || req_done !== ed) begin
            errors++;
            $display("FAIL %s: strb=%h latch=%b done=%b expected strb=%h latch=%b done=%b",
                     req, strb_o, latch_o, req_done, es, el, ed);
        end
        @(negedge clk);
    endtask

    task automatic load(input logic [3:0] a, input logic [6:0] d);
        @(negedge clk);
        pat_we = 1'b1; pat_addr = a; pat_wdata = d;
        @(negedge clk);
        pat_we = 1'b0;
    endtask

    task automatic start(input logic [3:0] idx, input logic wait_now);
        @(negedge clk);
        req_start = 1'b1; req_idx = idx;
        if (wait_now) ext_wait = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
    endtask

    task automatic t_reset();
        chk(4'h0, 1'b0, 1'b0, "R1");
    endtask

    task automatic t_plain();
        start(4'd0, 1'b0);
        chk(4'h1, 1'b0, 1'b0, "R2");
        chk(4'h2, 1'b0, 1'b0, "R2");
        chk(4'h4, 1'b1, 1'b0, "R3");
        chk(4'h8, 1'b0, 1'b0, "R2");
        chk(4'h0, 1'b0, 1'b1, "R4");
        chk(4'h0, 1'b0, 1'b0, "R4");
    endtask

    task automatic t_wait_disabled();
        cfg_wait_en = 1'b0; ext_wait = 1'b1;
        repeat (3) @(negedge clk);
        start(4'd4, 1'b0);
        chk(4'h3, 1'b0, 1'b0, "R5");
        chk(4'h5, 1'b0, 1'b0, "R5");
        chk(4'h6, 1'b1, 1'b0, "R5");
        chk(4'h9, 1'b0, 1'b0, "R5");
        chk(4'h0, 1'b0, 1'b1, "R5");
        ext_wait = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_freeze();
        cfg_wait_en = 1'b1; ext_wait = 1'b1;
        repeat (3) @(negedge clk);
        start(4'd4, 1'b0);
        chk(4'h3, 1'b0, 1'b0, "R7");
        chk(4'h5, 1'b0, 1'b0, "R7");
        chk(4'h5, 1'b0, 1'b0, "R7");
        chk(4'h5, 1'b0, 1'b0, "R7");
        chk(4'h5, 1'b0, 1'b0, "R7");
        ext_wait = 1'b0;
        chk(4'h5, 1'b0, 1'b0, "R8");
        chk(4'h5, 1'b0, 1'b0, "R8");
        chk(4'h5, 1'b0, 1'b0, "R8");
        chk(4'h6, 1'b1, 1'b0, "R8");
        chk(4'h9, 1'b0, 1'b0, "R8");
        chk(4'h0, 1'b0, 1'b1, "R8");
    endtask

    task automatic t_latch_frozen();
        cfg_wait_en = 1'b1; ext_wait = 1'b1;
        repeat (3) @(negedge clk);
        start(4'd8, 1'b0);
        chk(4'hA, 1'b0, 1'b0, "R9");
        chk(4'hA, 1'b0, 1'b0, "R9");
        ext_wait = 1'b0;
        chk(4'hA, 1'b0, 1'b0, "R9");
        chk(4'hA, 1'b0, 1'b0, "R9");
        chk(4'hA, 1'b0, 1'b0, "R9");
        chk(4'hC, 1'b0, 1'b0, "R8");
        chk(4'h0, 1'b0, 1'b1, "R4");
        repeat (3) @(negedge clk);
        start(4'd8, 1'b0);
        chk(4'hA, 1'b1, 1'b0, "R3");
        chk(4'hC, 1'b0, 1'b0, "R3");
        chk(4'h0, 1'b0, 1'b1, "R4");
    endtask

    task automatic t_sync_edge();
        cfg_wait_en = 1'b1; ext_wait = 1'b0;
        repeat (3) @(negedge clk);
        start(4'd4, 1'b1);
        chk(4'h3, 1'b0, 1'b0, "R6");
        chk(4'h5, 1'b0, 1'b0, "R6");
        chk(4'h5, 1'b0, 1'b0, "R6");
        ext_wait = 1'b0;
        chk(4'h5, 1'b0, 1'b0, "R6");
        chk(4'h5, 1'b0, 1'b0, "R6");
        chk(4'h5, 1'b0, 1'b0, "R6");
        chk(4'h6, 1'b1, 1'b0, "R6");
        chk(4'h9, 1'b0, 1'b0, "R6");
        chk(4'h0, 1'b0, 1'b1, "R6");
        repeat (3) @(negedge clk);
        start(4'd4, 1'b0);
        ext_wait = 1'b1;
        chk(4'h3, 1'b0, 1'b0, "R6");
        chk(4'h5, 1'b0, 1'b0, "R6");
        chk(4'h6, 1'b1, 1'b0, "R6");
        chk(4'h9, 1'b0, 1'b0, "R6");
        chk(4'h0, 1'b0, 1'b1, "R6");
        ext_wait = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_busy();
        cfg_wait_en = 1'b0;
        start(4'd0, 1'b0);
        chk(4'h1, 1'b0, 1'b0, "R2");
        pat_we = 1'b1; pat_addr = 4'd1; pat_wdata = 7'h0F;
        req_start = 1'b1; req_idx = 4'd8;
        chk(4'h2, 1'b0, 1'b0, "R11");
        pat_we = 1'b0; req_start = 1'b0;
        chk(4'h4, 1'b1, 1'b0, "R11");
        chk(4'h8, 1'b0, 1'b0, "R11");
        chk(4'h0, 1'b0, 1'b1, "R11");
        start(4'd0, 1'b0);
        chk(4'h1, 1'b0, 1'b0, "R10");
        chk(4'h2, 1'b0, 1'b0, "R10");
        repeat (4) @(negedge clk);
        load(4'd1, 7'h0F);
        start(4'd0, 1'b0);
        chk(4'h1, 1'b0, 1'b0, "R10");
        chk(4'hF, 1'b0, 1'b0, "R10");
        chk(4'h4, 1'b1, 1'b0, "R10");
        chk(4'h8, 1'b0, 1'b0, "R10");
        chk(4'h0, 1'b0, 1'b1, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        load(4'd0, 7'h01);
        load(4'd1, 7'h02);
        load(4'd2, 7'h14);
        load(4'd3, 7'h48);
        load(4'd4, 7'h03);
        load(4'd5, 7'h25);
        load(4'd6, 7'h16);
        load(4'd7, 7'h49);
        load(4'd8, 7'h3A);
        load(4'd9, 7'h4C);
        t_plain();
        t_wait_disabled();
        t_freeze();
        t_latch_frozen();
        t_sync_edge();
        t_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule